// File: doc/BRIEF.md
# Serial Sampling Converter Port with Power-Mode Control

This block is the device-side digital logic of a 16-clock serial sampling converter. A host lowers the chip-select line and toggles a serial clock. The block answers on a serial data line. That line has its own output-enable, which models three-state. Each frame carries four zero bits, then the sample word with the most significant bit first. When the sample is narrower than twelve bits, zero bits pad the frame at the end. The sample arrives on a parallel input and is captured when the frame opens.

The same two host lines also set the power mode. The mode depends on how many serial-clock falling edges have been counted when chip-select goes high again:
- Releasing chip-select early in the frame, but not at once, aborts the frame and sends the block to power-down.
- Releasing chip-select at once, or late in the frame, leaves the block in normal mode.

A frame started in power-down is a wake-up frame. Its data is not valid. It restores normal mode only if chip-select stays low through the tenth falling edge. The block reports the track/hold state, the mode, a power-good flag and a data-valid flag.

All inputs are sampled on a fast system clock. Edges of chip-select and the serial clock are detected against a registered copy of each input.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, sdo_oe=0, track=1, pd_mode=0, pwr_good=1 and data_valid=0.
- R2: A chip-select falling edge sets sdo_oe=1 with sdo=0 (first zero bit) and puts track/hold in hold (track=0).
- R3: After the n-th serial-clock falling edge (n=1..15), sdo carries bit 15-n of the 16-bit word {4'b0, sample, (12-RES_W) zero bits}.
- R4: The 16th falling edge sets sdo_oe=0. Later serial-clock edges in the same frame leave sdo_oe=0.
- R5: Chip-select rising before the 16th falling edge sets sdo_oe=0.
- R6: In normal mode, chip-select rising with a count of 2 to 9 falling edges sets pd_mode=1 and track=0.
- R7: In normal mode, chip-select rising with a count of 0, 1 or 10 or more keeps pd_mode=0 and returns track=1.
- R8: In a normal frame, track returns to 1 on the first serial-clock rising edge after the 13th falling edge.
- R9: In a wake-up frame, chip-select rising before the 10th falling edge keeps pd_mode=1 and track=0.
- R10: In a wake-up frame, pd_mode clears on the 10th falling edge. pwr_good stays 0 until the 16th falling edge or the chip-select rise, whichever comes first.
- R11: In a wake-up frame, track becomes 1 on the first serial-clock edge after chip-select falls.
- R12: data_valid=1 exactly while sdo_oe=1 in a frame that began in normal mode.
- R13: Serial-clock edges while chip-select is high change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip-select from the host |
| sclk | input | 1 | Serial clock from the host |
| sample | input | RES_W | Conversion result, captured when chip-select falls |
| sdo | output | 1 | Serial data bit, 0 while disabled |
| sdo_oe | output | 1 | Serial data drive enable (0 = three-state) |
| track | output | 1 | 1 = track/hold tracking, 0 = holding |
| pd_mode | output | 1 | 1 = power-down mode |
| pwr_good | output | 1 | 1 = fully powered and not in a wake-up frame |
| data_valid | output | 1 | Current frame carries a valid result |

## Verification
Each output settles on the first system-clock edge after the host line change that causes it. The bench therefore changes one host line just after a falling system-clock edge and checks all outputs one full clock later, before the next change. The word bits after the n-th falling edge, the mode at chip-select release, and the track/hold and power-good transitions are all computed in the bench. The sweep covers release points from 0 to 16 falling edges, first from normal mode and then from power-down.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W     = 12,
  parameter int FRAME_LEN = 16,
  parameter int LEAD      = 4,
  parameter int PD_LO     = 2,
  parameter int PD_HI     = 10,
  parameter int TRACK_AT  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [RES_W-1:0] sample,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             track,
  output logic             pd_mode,
  output logic             pwr_good,
  output logic             data_valid
);
  localparam int CW  = $clog2(FRAME_LEN + 1);
  localparam int PAD = FRAME_LEN - LEAD - RES_W;
  localparam logic [CW-1:0] C_END   = CW'(FRAME_LEN);
  localparam logic [CW-1:0] C_LAST  = CW'(FRAME_LEN - 1);
  localparam logic [CW-1:0] C_PDLO  = CW'(PD_LO);
  localparam logic [CW-1:0] C_PDHI  = CW'(PD_HI);
  localparam logic [CW-1:0] C_WAKE  = CW'(PD_HI - 1);
  localparam logic [CW-1:0] C_TRK   = CW'(TRACK_AT);

  logic                 cs_q, sclk_q, act, waking, frame_ok;
  logic [CW-1:0]        cnt;
  logic [FRAME_LEN-1:0] sreg;

  wire cs_fall  = cs_q & ~cs_n;
  wire cs_rise  = ~cs_q & cs_n;
  wire sck_fall = sclk_q & ~sclk;
  wire sck_rise = ~sclk_q & sclk;
  wire done     = (cnt == C_END);
  wire [FRAME_LEN-1:0] load = FRAME_LEN'(sample) << PAD;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q     <= 1'b1;
      sclk_q   <= 1'b1;
      act      <= 1'b0;
      waking   <= 1'b0;
      frame_ok <= 1'b0;
      cnt      <= '0;
      sreg     <= '0;
      sdo_oe   <= 1'b0;
      track    <= 1'b1;
      pd_mode  <= 1'b0;
    end else begin
      cs_q   <= cs_n;
      sclk_q <= sclk;
      if (cs_fall) begin
        act      <= 1'b1;
        cnt      <= '0;
        sreg     <= load;
        sdo_oe   <= 1'b1;
        frame_ok <= ~pd_mode;
        waking   <= pd_mode;
        track    <= 1'b0;
      end else if (cs_rise && act) begin
        act    <= 1'b0;
        sdo_oe <= 1'b0;
        waking <= 1'b0;
        if (waking)
          track <= (cnt >= C_PDHI);
        else if (cnt >= C_PDLO && cnt < C_PDHI) begin
          pd_mode <= 1'b1;
          track   <= 1'b0;
        end else
          track <= 1'b1;
      end else if (act && !cs_n) begin
        if (sck_fall && !done) begin
          cnt  <= cnt + 1'b1;
          sreg <= sreg << 1;
          if (cnt == C_LAST) begin
            sdo_oe <= 1'b0;
            waking <= 1'b0;
          end
          if (waking && cnt == C_WAKE)
            pd_mode <= 1'b0;
        end
        if (waking && (sck_fall || sck_rise))
          track <= 1'b1;
        if (sck_rise && cnt >= C_TRK)
          track <= 1'b1;
      end
    end
  end

  assign sdo        = sdo_oe & sreg[FRAME_LEN-1];
  assign pwr_good   = ~pd_mode & ~waking;
  assign data_valid = sdo_oe & frame_ok;
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdo,
  input logic sdo_oe,
  input logic track,
  input logic pd_mode,
  input logic pwr_good,
  input logic data_valid
);
  p_oe_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !sdo_oe);

  p_first_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> !sdo);

  p_hold_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(track) |-> (!$past(cs_n) || pd_mode));

  p_pd_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_mode) |-> ($past(cs_n) && !sdo_oe && !track));

  p_wake_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_mode) |-> (track && !pwr_good && !cs_n));

  p_valid_power_r12: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (pwr_good && !pd_mode));
endmodule

bind adc_serial_port adc_serial_port_chk u_chk (.*);

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
  localparam int W = 10;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1;
  logic [W-1:0] sample = '0;
  logic sdo, sdo_oe, track, pd_mode, pwr_good, data_valid;
  int checks = 0, errors = 0;
  bit pd_e = 1'b0, tr_e = 1'b1;

  adc_serial_port #(.RES_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample),
    .sdo(sdo), .sdo_oe(sdo_oe), .track(track), .pd_mode(pd_mode),
    .pwr_good(pwr_good), .data_valid(data_valid));

  always #10 clk = ~clk;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b", req, what, got, exp);
    end
  endtask

  task automatic frame(int k, logic [W-1:0] v);
    bit wake = pd_e;
    bit ok = !pd_e;
    logic [15:0] word = 16'(v) << (12 - W);
    sample = v;
    cs_n = 1'b0; step();
    tr_e = 1'b0;
    chk("R2", "sdo_oe", sdo_oe, 1'b1);
    chk("R2", "sdo", sdo, 1'b0);
    chk("R2", "track", track, 1'b0);
    chk("R12", "data_valid", data_valid, ok);
    for (int i = 1; i <= k; i++) begin
      sclk = 1'b0; step();
      if (wake) tr_e = 1'b1;
      if (wake && i == 10) pd_e = 1'b0;
      if (i < 16) begin
        chk("R3", "sdo_oe", sdo_oe, 1'b1);
        chk("R3", "sdo", sdo, word[15-i]);
      end else
        chk("R4", "sdo_oe", sdo_oe, 1'b0);
      chk("R12", "data_valid", data_valid, ok && i < 16);
      chk("R10", "pd_mode", pd_mode, pd_e);
      chk("R10", "pwr_good", pwr_good, wake ? (i >= 16) : 1'b1);
      chk("R11", "track after fall", track, tr_e);
      sclk = 1'b1; step();
      if (i >= 13) tr_e = 1'b1;
      chk("R8", "track after rise", track, tr_e);
    end
    if (k == 16) begin
      sclk = 1'b0; step();
      chk("R4", "sdo_oe extra edge", sdo_oe, 1'b0);
      chk("R4", "sdo extra edge", sdo, 1'b0);
      sclk = 1'b1; step();
    end
    cs_n = 1'b1; step();
    if (wake) begin
      if (k < 10) begin pd_e = 1'b1; tr_e = 1'b0; end
      else tr_e = 1'b1;
    end else if (k >= 2 && k < 10) begin
      pd_e = 1'b1; tr_e = 1'b0;
    end else tr_e = 1'b1;
    chk("R5", "sdo_oe", sdo_oe, 1'b0);
    chk(wake ? "R9" : (pd_e ? "R6" : "R7"), "pd_mode", pd_mode, pd_e);
    chk(wake ? "R9" : "R7", "track", track, tr_e);
    chk("R10", "pwr_good", pwr_good, !pd_e);
    chk("R12", "data_valid", data_valid, 1'b0);
    for (int j = 0; j < 3; j++) begin
      sclk = 1'b0; step();
      sclk = 1'b1; step();
    end
    chk("R13", "sdo_oe idle", sdo_oe, 1'b0);
    chk("R13", "pd_mode idle", pd_mode, pd_e);
    chk("R13", "track idle", track, tr_e);
    chk("R13", "pwr_good idle", pwr_good, !pd_e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all requirements got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1; step();
    chk("R1", "sdo_oe", sdo_oe, 1'b0);
    chk("R1", "track", track, 1'b1);
    chk("R1", "pd_mode", pd_mode, 1'b0);
    chk("R1", "pwr_good", pwr_good, 1'b1);
    chk("R1", "data_valid", data_valid, 1'b0);
    for (int k = 0; k <= 16; k++) begin
      if (pd_e) frame(16, W'(k * 29 + 3));
      frame(k, W'(10'h2A5 ^ (k * 37)));
    end
    for (int k = 0; k <= 16; k++) begin
      if (!pd_e) frame(5, W'(k));
      frame(k, W'(10'h15A + k * 41));
    end
    frame(16, W'(10'h3FF));
    frame(16, W'(10'h201));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule